// File: doc/BRIEF.md
# Multiword DMA Host Burst Controller

This block is the host side of a multiword DMA transfer on a parallel disk bus. Software or a command engine starts a transfer by giving it a direction, a timing mode (0, 1 or 2) and a word count. The controller then waits for the device to request service. It answers with an acknowledge and forces both chip selects inactive for as long as the acknowledge is held. It then produces a train of read or write strobe pulses, and each pulse moves one 16-bit word between the bus and a show-ahead word FIFO on the host side.

A burst ends in one of two ways. The device can end it by dropping its request during a pulse, and the word of that pulse is then the last one. The host can end it after any pulse when its FIFO cannot take or give another word, or when the word count is used up. While words remain, the controller waits for the request again and opens a new burst. It does this as often as needed until the count reaches zero, and then it pulses `done_o`.

Strobe timing comes from nanosecond figures for each mode. These figures are converted into clock counts at elaboration, for the clock period set by a parameter. The mode is chosen when a transfer starts. Bus inputs are expected to be synchronous to `clk`.

Top module: `mdma_host_ctrl`

## Requirements
- R1: `dmack_n_o` is asserted (driven low) only in the clock after one where `dmarq_i` was high, a transfer was pending and the host FIFO was ready (read: `rx_full_i` low; write: `tx_empty_i` low). With no request, the acknowledge stays high.
- R2: While `dmack_n_o` is low, `cs_n_o` is 2'b11. While it is high, `cs_n_o` follows `pio_cs_n_i`. A strobe (`dior_n_o` or `diow_n_o` low) appears only while the acknowledge is low, and the two strobes are never low together.
- R3: Each strobe stays low for exactly ceil(T/CLK_NS) clocks. T is 215 ns in mode 0 (`mode_i`=0), 80 ns in mode 1 and 70 ns in mode 2. `mode_i`=3 behaves as mode 2.
- R4: Between pulses, the strobe stays high for at least ceil(N/CLK_NS) clocks. N is 50/50/25 ns for reads and 215/50/25 ns for writes, in modes 0/1/2. The time from one falling edge to the next is at least ceil(C/CLK_NS) clocks, with C = 480/150/120 ns.
- R5: On writes (`rd_i`=0), one word is popped from the TX FIFO per pulse, in order, and driven on `dd_o` with `dd_oe_o` high. The word is stable for at least ceil(100/30/20 ns) before the strobe falls. It stays stable for at least ceil(20/15/10 ns) after the strobe rises.
- R6: On reads (`rd_i`=1), `dd_i` is captured at the clock edge where `dior_n_o` rises. It is pushed to the RX FIFO once per pulse, in order, with `rx_push_o` high for one clock.
- R7: If `dmarq_i` is low during a pulse, that pulse moves the last word of the burst. The acknowledge is then released and no further pulse follows in that burst.
- R8: The host releases the acknowledge after a pulse when the RX FIFO is full (reads) or the TX FIFO is empty (writes). It does not open a burst while that condition holds.
- R9: A transfer makes exactly `word_count_i` pulses in total. `done_o` is high for one clock as `busy_o` falls. A count of zero gives `done_o` in the clock after the start, with no acknowledge.
- R10: When a burst has ended with words still left, a new burst opens once `dmarq_i` is high and the FIFO is ready again. The transfer then resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a transfer (accepted while idle) |
| rd_i | input | 1 | 1 = device to host, 0 = host to device |
| mode_i | input | 2 | Timing mode 0..2 (3 acts as 2) |
| word_count_i | input | WCNT_W | Words to move |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-clock completion pulse |
| pio_cs_n_i | input | 2 | Chip selects used outside DMA bursts |
| dmarq_i | input | 1 | Device request |
| dmack_n_o | output | 1 | Acknowledge, active low |
| cs_n_o | output | 2 | Chip selects to bus, active low |
| dior_n_o | output | 1 | Read strobe, active low |
| diow_n_o | output | 1 | Write strobe, active low |
| dd_i | input | DW | Bus data from device |
| dd_o | output | DW | Bus data to device |
| dd_oe_o | output | 1 | Output enable for `dd_o` |
| rx_data_o | output | DW | Word to RX FIFO |
| rx_push_o | output | 1 | RX FIFO write |
| rx_full_i | input | 1 | RX FIFO full |
| tx_data_i | input | DW | Head word of TX FIFO (show-ahead) |
| tx_pop_o | output | 1 | TX FIFO read |
| tx_empty_i | input | 1 | TX FIFO empty |

## Verification
The bench measures every strobe low time, high time and period in clocks and compares them with figures it derives itself from the nanosecond limits. A design that mixes up the read and write timing, or that misreads mode 3, gives a wrong width. The bench drops the request in the middle of a burst and also stalls the host FIFOs part way through. A controller that ignores a drop during a pulse would make an extra pulse. One that never resumes would leave words unmoved and no done pulse. One that loses or repeats a word at the break would fail the word-by-word data compare. The bench also starts transfers with no request, with a full RX FIFO and with a zero count. The acknowledge must stay inactive in each of these cases.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETUP,
    ST_ACT,
    ST_RECOV
  } mdma_state_e;

  // Strobe asserted width per mode, ns
  function automatic int act_ns(input int m);
    case (m)
      0:       return 215;
      1:       return 80;
      default: return 70;
    endcase
  endfunction

  // Minimum strobe-high time per mode and direction, ns
  function automatic int neg_ns(input int m, input bit rd);
    case (m)
      0:       return rd ? 50 : 215;
      1:       return 50;
      default: return 25;
    endcase
  endfunction

  // Minimum fall-to-fall period, ns
  function automatic int cyc_ns(input int m);
    case (m)
      0:       return 480;
      1:       return 150;
      default: return 120;
    endcase
  endfunction

  // Write data setup before strobe fall, ns
  function automatic int su_ns(input int m);
    case (m)
      0:       return 100;
      1:       return 30;
      default: return 20;
    endcase
  endfunction

  // Write data hold after strobe rise, ns
  function automatic int hold_ns(input int m);
    case (m)
      0:       return 20;
      1:       return 15;
      default: return 10;
    endcase
  endfunction

  function automatic int ns2clk(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  // Recovery: satisfies negated width, hold and the remainder of the period
  function automatic int rec_clk(input int m, input bit rd, input int clk_ns);
    int a, r;
    a = ns2clk(act_ns(m), clk_ns);
    r = ns2clk(neg_ns(m, rd), clk_ns);
    if (ns2clk(cyc_ns(m), clk_ns) - a > r) r = ns2clk(cyc_ns(m), clk_ns) - a;
    if (!rd && ns2clk(hold_ns(m), clk_ns) > r) r = ns2clk(hold_ns(m), clk_ns);
    return r;
  endfunction

endpackage

// File: rtl/mdma_timing.sv
module mdma_timing #(
  parameter int CLK_NS = 5,
  parameter int CNT_W  = 8
) (
  input  logic [1:0]       mode_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] t_setup_o,
  output logic [CNT_W-1:0] t_act_o,
  output logic [CNT_W-1:0] t_rec_o
);
  import mdma_pkg::*;

  localparam int NMODE = 3;

  logic [CNT_W-1:0] su_tab   [NMODE];
  logic [CNT_W-1:0] act_tab  [NMODE];
  logic [CNT_W-1:0] recr_tab [NMODE];
  logic [CNT_W-1:0] recw_tab [NMODE];

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    assign su_tab[m]   = CNT_W'(ns2clk(su_ns(m), CLK_NS));
    assign act_tab[m]  = CNT_W'(ns2clk(act_ns(m), CLK_NS));
    assign recr_tab[m] = CNT_W'(rec_clk(m, 1'b1, CLK_NS));
    assign recw_tab[m] = CNT_W'(rec_clk(m, 1'b0, CLK_NS));
  end

  logic [1:0] sel;
  assign sel = (mode_i == 2'd3) ? 2'd2 : mode_i;

  always_comb begin
    t_act_o   = act_tab[sel];
    t_setup_o = rd_i ? CNT_W'(1) : su_tab[sel];
    t_rec_o   = rd_i ? recr_tab[sel] : recw_tab[sel];
  end

endmodule

// File: rtl/mdma_phase_cnt.sv
module mdma_phase_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             end_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load_i)            cnt_n = len_i - CNT_W'(1);
    else if (cnt_q != '0)  cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign end_o = (cnt_q == '0);

endmodule

// File: rtl/mdma_host_ctrl.sv
module mdma_host_ctrl #(
  parameter int CLK_NS = 5,
  parameter int WCNT_W = 16,
  parameter int DW     = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [1:0]        mode_i,
  input  logic [WCNT_W-1:0] word_count_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic [1:0]        pio_cs_n_i,
  input  logic              dmarq_i,
  output logic              dmack_n_o,
  output logic [1:0]        cs_n_o,
  output logic              dior_n_o,
  output logic              diow_n_o,
  input  logic [DW-1:0]     dd_i,
  output logic [DW-1:0]     dd_o,
  output logic              dd_oe_o,
  output logic [DW-1:0]     rx_data_o,
  output logic              rx_push_o,
  input  logic              rx_full_i,
  input  logic [DW-1:0]     tx_data_i,
  output logic              tx_pop_o,
  input  logic              tx_empty_i
);
  import mdma_pkg::*;

  mdma_state_e       state_q, state_n;
  logic [WCNT_W-1:0] rem_q, rem_n;
  logic [1:0]        mode_q, mode_n;
  logic              rd_q, rd_n;
  logic              last_q, last_n;
  logic              done_q, done_n;
  logic              ack_n_q, dior_q, diow_q;
  logic [DW-1:0]     dd_q, rx_q;
  logic              push_q;
  logic              load, pop, cap, ready, in_burst;
  logic [CNT_W-1:0]  len;
  logic [CNT_W-1:0]  t_setup, t_act, t_rec;
  logic              cnt_end;

  mdma_timing #(.CLK_NS(CLK_NS), .CNT_W(CNT_W)) u_timing (
    .mode_i    (mode_q),
    .rd_i      (rd_q),
    .t_setup_o (t_setup),
    .t_act_o   (t_act),
    .t_rec_o   (t_rec)
  );

  mdma_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .len_i  (len),
    .end_o  (cnt_end)
  );

  assign ready = rd_q ? !rx_full_i : !tx_empty_i;

  // Next-state logic
  always_comb begin
    state_n = state_q;
    rem_n   = rem_q;
    mode_n  = mode_q;
    rd_n    = rd_q;
    last_n  = last_q;
    done_n  = 1'b0;
    load    = 1'b0;
    len     = t_setup;
    pop     = 1'b0;
    cap     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          mode_n = mode_i;
          rd_n   = rd_i;
          rem_n  = word_count_i;
          if (word_count_i == '0) done_n  = 1'b1;
          else                    state_n = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (dmarq_i && ready) begin
          state_n = ST_SETUP;
          load    = 1'b1;
          len     = t_setup;
          pop     = !rd_q;
          last_n  = 1'b0;
        end
      end
      ST_SETUP: begin
        if (cnt_end) begin
          state_n = ST_ACT;
          load    = 1'b1;
          len     = t_act;
        end
      end
      ST_ACT: begin
        if (!dmarq_i) last_n = 1'b1;
        if (cnt_end) begin
          state_n = ST_RECOV;
          load    = 1'b1;
          len     = t_rec;
          rem_n   = rem_q - WCNT_W'(1);
          cap     = rd_q;
        end
      end
      ST_RECOV: begin
        if (cnt_end) begin
          if (rem_q == '0) begin
            state_n = ST_IDLE;
            done_n  = 1'b1;
          end else if (last_q || !dmarq_i || !ready) begin
            state_n = ST_WAIT;
          end else begin
            state_n = ST_SETUP;
            load    = 1'b1;
            len     = t_setup;
            pop     = !rd_q;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign in_burst = (state_n == ST_SETUP) || (state_n == ST_ACT) || (state_n == ST_RECOV);

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      mode_q  <= '0;
      rd_q    <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      ack_n_q <= 1'b1;
      dior_q  <= 1'b1;
      diow_q  <= 1'b1;
      push_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      rem_q   <= rem_n;
      mode_q  <= mode_n;
      rd_q    <= rd_n;
      last_q  <= last_n;
      done_q  <= done_n;
      ack_n_q <= !in_burst;
      dior_q  <= !((state_n == ST_ACT) && rd_n);
      diow_q  <= !((state_n == ST_ACT) && !rd_n);
      push_q  <= cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dd_q <= '0;
    else if (pop) dd_q <= tx_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rx_q <= '0;
    else if (cap) rx_q <= dd_i;
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign dmack_n_o = ack_n_q;
  assign cs_n_o    = ack_n_q ? pio_cs_n_i : 2'b11;
  assign dior_n_o  = dior_q;
  assign diow_n_o  = diow_q;
  assign dd_o      = dd_q;
  assign dd_oe_o   = !ack_n_q && !rd_q;
  assign rx_data_o = rx_q;
  assign rx_push_o = push_q;
  assign tx_pop_o  = pop;

  // Assertions
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dmack_n_o) |-> $past(dmarq_i)); // R1
  AST_STROBE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (!dior_n_o || !diow_n_o) |-> (!dmack_n_o && (cs_n_o == 2'b11))); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~dior_n_o, ~diow_n_o})); // R2
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !diow_n_o |-> $stable(dd_o)); // R5
  AST_PUSH_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_o |-> $rose(dior_n_o)); // R6
  AST_NO_EXTRA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dior_n_o) || $fell(diow_n_o)) |-> (rem_q != '0)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && dmack_n_o)); // R9

endmodule

// File: tb/mdma_host_ctrl_tb.sv
module mdma_host_ctrl_tb_top;
  localparam int DW = 16;
  localparam int WCNT_W = 16;
  localparam int NVEC = 8;
  localparam int BIG = 1 << 20;

  // {mode[1:0], rd, count[7:0], stop_at[7:0], fifo_limit[7:0]}
  localparam logic [26:0] VEC [0:NVEC-1] = '{
    {2'd0, 1'b1, 8'd3, 8'd0, 8'd0},
    {2'd1, 1'b0, 8'd5, 8'd0, 8'd0},
    {2'd2, 1'b1, 8'd6, 8'd2, 8'd0},
    {2'd2, 1'b0, 8'd6, 8'd0, 8'd3},
    {2'd1, 1'b1, 8'd5, 8'd0, 8'd2},
    {2'd0, 1'b0, 8'd4, 8'd3, 8'd0},
    {2'd2, 1'b0, 8'd2, 8'd0, 8'd0},
    {2'd3, 1'b1, 8'd2, 8'd0, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rd = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [WCNT_W-1:0] wcount = '0;
  logic busy, done, dmarq = 1'b0, dmack_n, dior_n, diow_n, dd_oe;
  logic [1:0] pio_cs_n = 2'b10, cs_n;
  logic [DW-1:0] dd_in = '0, dd_out, rx_data, tx_data;
  logic rx_push, rx_full, tx_pop, tx_empty;

  int cyc = 0, n_chk = 0, n_bad = 0;
  int rx_cnt = 0, rx_cap = BIG, tx_rd = 0, tx_avail = BIG;
  logic [DW-1:0] rx_mem [0:63];
  logic [DW-1:0] dev_mem [0:63];
  logic [DW-1:0] rx_base = '0, tx_base = '0;

  bit dev_en = 0, held = 0;
  int dev_cnt = 0, dev_stop = 0, pause = 0, cur_mode = 0;
  int pulses, bursts, act_min, act_max, neg_min, per_min, su_err, hold_err, r2_err;
  int fall_cyc, rise_cyc, dd_chg_cyc;
  bit have_fall, have_rise;

  always #2.5 clk = ~clk;

  mdma_host_ctrl #(.CLK_NS(5), .WCNT_W(WCNT_W), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rd_i(rd), .mode_i(mode),
    .word_count_i(wcount), .busy_o(busy), .done_o(done), .pio_cs_n_i(pio_cs_n),
    .dmarq_i(dmarq), .dmack_n_o(dmack_n), .cs_n_o(cs_n), .dior_n_o(dior_n),
    .diow_n_o(diow_n), .dd_i(dd_in), .dd_o(dd_out), .dd_oe_o(dd_oe),
    .rx_data_o(rx_data), .rx_push_o(rx_push), .rx_full_i(rx_full),
    .tx_data_i(tx_data), .tx_pop_o(tx_pop), .tx_empty_i(tx_empty)
  );

  assign rx_full  = (rx_cnt >= rx_cap);
  assign tx_empty = (tx_rd >= tx_avail);
  assign tx_data  = tx_base + DW'(tx_rd);

  // Host FIFO models and cycle count
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rx_push && rx_cnt < 64) begin
      rx_mem[rx_cnt] <= rx_data;
      rx_cnt <= rx_cnt + 1;
    end
    if (tx_pop) tx_rd <= tx_rd + 1;
  end

  function automatic int cdiv(input int ns);
    return (ns + 4) / 5;
  endfunction
  function automatic int e_act(input int m);
    return (m == 0) ? cdiv(215) : (m == 1) ? cdiv(80) : cdiv(70);
  endfunction
  function automatic int e_neg(input int m, input bit r);
    if (m == 0) return r ? cdiv(50) : cdiv(215);
    return (m == 1) ? cdiv(50) : cdiv(25);
  endfunction
  function automatic int e_per(input int m);
    return (m == 0) ? cdiv(480) : (m == 1) ? cdiv(150) : cdiv(120);
  endfunction
  function automatic int e_su(input int m);
    return (m == 0) ? cdiv(100) : (m == 1) ? cdiv(30) : cdiv(20);
  endfunction
  function automatic int e_hold(input int m);
    return (m == 0) ? cdiv(20) : (m == 1) ? cdiv(15) : cdiv(10);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Device model and bus monitor
  initial begin
    logic prev_s, prev_ack, s, wr_pulse;
    logic [DW-1:0] prev_dd;
    prev_s = 1'b1; prev_ack = 1'b1; prev_dd = '0; wr_pulse = 1'b0;
    forever begin
      @(negedge clk);
      s = dior_n & diow_n;
      if (dd_out != prev_dd) begin
        if (have_rise && s && (cyc - rise_cyc) < e_hold(cur_mode)) hold_err++;
        dd_chg_cyc = cyc;
        prev_dd = dd_out;
      end
      if (prev_s && !s) begin
        pulses++;
        if (have_rise && (cyc - rise_cyc) < neg_min) neg_min = cyc - rise_cyc;
        if (have_fall && (cyc - fall_cyc) < per_min) per_min = cyc - fall_cyc;
        fall_cyc = cyc; have_fall = 1;
        wr_pulse = !diow_n;
        if (wr_pulse && (cyc - dd_chg_cyc) < e_su(cur_mode)) su_err++;
        if (!dior_n) dd_in = rx_base + DW'(pulses - 1);
        if (pulses == dev_stop && pulses < dev_cnt) begin held = 1; pause = 30; end
      end
      if (!prev_s && s) begin
        if ((cyc - fall_cyc) < act_min) act_min = cyc - fall_cyc;
        if ((cyc - fall_cyc) > act_max) act_max = cyc - fall_cyc;
        rise_cyc = cyc; have_rise = 1;
        if (wr_pulse && pulses >= 1 && pulses <= 64) dev_mem[pulses-1] = dd_out;
      end
      if (prev_ack && !dmack_n) bursts++;
      prev_ack = dmack_n;
      if (!dmack_n && cs_n != 2'b11) r2_err++;
      if (dmack_n && cs_n != pio_cs_n) r2_err++;
      if (!s && dmack_n) r2_err++;
      if (!dior_n && !diow_n) r2_err++;
      if (held && dmack_n) begin
        if (pause > 0) pause--; else held = 0;
      end
      dmarq = dev_en && !held && (pulses < dev_cnt);
      prev_s = s;
    end
  end

  task automatic clear_stats();
    pulses = 0; bursts = 0; act_min = 1 << 30; act_max = 0; neg_min = 1 << 30;
    per_min = 1 << 30; su_err = 0; hold_err = 0; r2_err = 0; held = 0; pause = 0;
    have_fall = 0; have_rise = 0; fall_cyc = 0; rise_cyc = 0; dd_chg_cyc = 0;
    rx_cnt = 0; tx_rd = 0;
  endtask

  task automatic kick(input int m, input bit r, input int n);
    mode = 2'(m); rd = r; wcount = WCNT_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int lim, output bit seen);
    seen = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
  endtask

  task automatic run_vec(input int idx);
    int m, cnt, stop, lim, exp_b;
    bit r, seen;
    m = int'(VEC[idx][26:25]); r = VEC[idx][24]; cnt = int'(VEC[idx][23:16]);
    stop = int'(VEC[idx][15:8]); lim = int'(VEC[idx][7:0]);
    @(negedge clk);
    clear_stats();
    cur_mode = (m == 3) ? 2 : m;
    rx_base = DW'(16'h1000 * (idx + 1)); tx_base = DW'(16'h8100 + 16'h0100 * idx);
    rx_cap = (r && lim > 0) ? lim : BIG;
    tx_avail = (!r && lim > 0) ? lim : BIG;
    dev_cnt = cnt; dev_stop = stop; dev_en = 1;
    kick(m, r, cnt);
    if (lim > 0) begin
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (pulses == lim && dmack_n) break;
      end
      repeat (100) @(negedge clk);
      chk(pulses == lim && dmack_n && busy, "R8 stop at FIFO limit", pulses, lim);
      rx_cap = BIG; tx_avail = BIG;
    end
    wait_done(20000, seen);
    chk(seen, "R9 done pulse", int'(seen), 1);
    chk(pulses == cnt, "R9 pulse total", pulses, cnt);
    exp_b = 1 + ((stop > 0 && stop < cnt) ? 1 : 0) + ((lim > 0 && lim < cnt) ? 1 : 0);
    chk(bursts == exp_b, "R7/R8/R10 burst count", bursts, exp_b);
    chk(act_min == e_act(cur_mode) && act_max == e_act(cur_mode), "R3 strobe width",
        act_max, e_act(cur_mode));
    if (cnt > 1) begin
      chk(neg_min >= e_neg(cur_mode, r), "R4 negated width", neg_min, e_neg(cur_mode, r));
      chk(per_min >= e_per(cur_mode), "R4 period", per_min, e_per(cur_mode));
    end
    chk(r2_err == 0, "R2 select/acknowledge rules", r2_err, 0);
    if (r) begin
      chk(rx_cnt == cnt, "R6 pushes", rx_cnt, cnt);
      for (int k = 0; k < cnt && k < 64; k++)
        chk(rx_mem[k] == rx_base + DW'(k), "R6 read word", int'(rx_mem[k]),
            int'(rx_base + DW'(k)));
    end else begin
      chk(tx_rd == cnt, "R5 pops", tx_rd, cnt);
      for (int k = 0; k < cnt && k < 64; k++)
        chk(dev_mem[k] == tx_base + DW'(k), "R5 write word", int'(dev_mem[k]),
            int'(tx_base + DW'(k)));
      chk(su_err == 0 && hold_err == 0, "R5 setup/hold", su_err + hold_err, 0);
    end
    dev_en = 0;
    repeat (5) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    wait (cyc >= 150000);
    n_bad++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    bit seen;
    clear_stats();
    repeat (3) @(negedge clk);
    // reset state
    chk(dmack_n && dior_n && diow_n, "R2 reset strobes/ack", int'({dmack_n, dior_n, diow_n}), 7);
    chk(!busy && !done, "R9 reset busy/done", int'({busy, done}), 0);
    chk(cs_n == pio_cs_n, "R2 reset chip selects", int'(cs_n), int'(pio_cs_n));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NVEC; v++) run_vec(v);

    // zero count
    clear_stats();
    kick(1, 1'b1, 0);
    chk(done && !busy, "R9 zero count done", int'(done), 1);
    repeat (20) @(negedge clk);
    chk(bursts == 0 && dmack_n, "R9 zero count no ack", bursts, 0);

    // no request: acknowledge must wait, then resume
    clear_stats();
    rx_base = 16'h5500; cur_mode = 2; dev_cnt = 2; dev_stop = 0; dev_en = 0;
    rx_cap = BIG; tx_avail = BIG;
    kick(2, 1'b1, 2);
    repeat (200) @(negedge clk);
    chk(dmack_n && busy && pulses == 0, "R1 no ack without request", int'(dmack_n), 1);
    dev_en = 1;
    wait_done(5000, seen);
    chk(seen && pulses == 2, "R10 start once request arrives", pulses, 2);
    dev_en = 0;
    repeat (5) @(negedge clk);

    // full RX FIFO: request present, no burst opened
    clear_stats();
    rx_cap = 0; dev_cnt = 2; dev_en = 1;
    kick(2, 1'b1, 2);
    repeat (200) @(negedge clk);
    chk(dmack_n && pulses == 0, "R8 no burst with full FIFO", pulses, 0);
    rx_cap = BIG;
    wait_done(5000, seen);
    chk(seen && rx_cnt == 2, "R10 resume after FIFO drains", rx_cnt, 2);
    dev_en = 0;
    repeat (5) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule